// File: doc/BRIEF.md
# Flow-Control Frame Generator (Pause and Priority Pause)

This block assembles the 64-byte MAC control frame that asks a link partner to stop, or to resume, sending traffic. It then streams the frame out one byte per accepted handshake, with the frame check sequence at the end. It works in one of two modes. Standard mode sends a classic pause frame that carries a single pause time. Priority mode sends a priority-based pause frame. That frame holds an enable vector and eight per-priority pause-time slots.

Each receive queue has a request pair: a trigger, asking the partner to pause, and a release, asking the partner to resume. Each queue also has a pause time and a mask of the priorities it owns. In priority mode, all requests pending at the moment a frame starts are merged into one frame. The frame's enable vector is the OR of the requesting queues' masks. Each owned slot holds that queue's pause time, or zero for a release. Requests that arrive while a frame is being sent are held and go into the next frame.

Top module: `fc_frame_gen`

## Requirements
- R1: Bytes 0-5 are 01 80 C2 00 00 01, bytes 6-11 are `src_addr_i` most significant byte first, and bytes 12-13 are 88 08.
- R2: Bytes 14-15 are 00 01 when `pfc_mode_i` is 0, and 01 01 when it is 1.
- R3: In standard mode (`pfc_mode_i`=0), bytes 16-17 hold queue 0's pause time, most significant byte first, or zero when queue 0 is releasing. Bytes 18-59 are zero. Requests on queues 1 and up are discarded and produce no frame.
- R4: In priority mode, byte 16 is zero and byte 17 is the enable vector, where bit p means priority p. Bytes 18+2p and 19+2p hold the 16-bit slot for priority p, most significant byte first. Bytes 34-59 are zero.
- R5: Each triggered queue ORs its priority mask into the enable vector and writes its pause time into every slot its mask covers. When masks overlap, the lowest-numbered queue owns the slot. All requests pending when a frame starts are merged into that one frame.
- R6: A release on a queue whose zero-quanta enable is set sets that queue's mask bits in the vector, with zero in its slots. A release while zero-quanta is clear is discarded. A trigger and a release on the same queue in the same cycle count as a trigger.
- R7: Bytes 60-63 carry the CRC-32 over bytes 0-59 (reflected polynomial 0xEDB88320, initial value all ones, result inverted), least significant byte first.
- R8: A byte advances only on a cycle with `tx_valid_o` and `tx_ready_i` both high. While ready is low, data and last hold steady. Every frame has exactly 64 bytes, and `tx_last_o` is high only on byte 63. After the last byte is accepted, valid drops for at least one cycle.
- R9: A request made during a frame is held and sent in the following frame. A frame's contents are captured when it starts, so later changes to pause times or masks do not alter it.
- R10: After reset, `tx_valid_o` and `tx_last_o` are low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_addr_i | input | 48 | Source MAC address |
| pfc_mode_i | input | 1 | 1 selects priority mode, 0 selects standard pause |
| trig_set_i | input | NQ | Per-queue pause trigger pulse |
| trig_rel_i | input | NQ | Per-queue release pulse |
| zq_en_i | input | NQ | Per-queue zero-quanta frame enable on release |
| pause_time_i | input | 16*NQ | Per-queue pause time, queue q at bits 16q+15:16q |
| prio_mask_i | input | 8*NQ | Per-queue priority mask, queue q at bits 8q+7:8q |
| tx_ready_i | input | 1 | Downstream accepts a byte |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Byte is valid |
| tx_last_o | output | 1 | Byte 63 of the frame |

## Verification
The assertions check the handshake rules on every cycle. Data and last must hold while stalled, last must sit exactly on the 64th accepted byte, and valid must drop after the last byte. The fixed first byte and the fixed low opcode byte are checked on every frame. The bench scenarios cover the content rules: merging of queue masks, ownership of overlapping slots, zero-quanta releases, discarded requests, the CRC, and the freezing and deferral of requests made mid-frame. These need a model of the whole frame.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int NPRI      = 8;
    localparam int FRAME_LEN = 64;
    localparam int BODY_LEN  = 60;
    localparam logic [47:0] CTRL_DA   = 48'h0180_C200_0001;
    localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;

    typedef struct packed {
        logic                  pfc;
        logic [47:0]           sa;
        logic [NPRI-1:0]       pev;
        logic [NPRI-1:0][15:0] slot;  // standard mode uses slot[0] only
    } fc_frame_t;

    typedef enum logic { ST_IDLE, ST_SEND } fc_state_e;

    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++)
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] body_byte(input fc_frame_t f, input logic [5:0] idx);
        int k;
        int p;
        logic [15:0] w;
        k = int'(idx);
        if (k < 6)        return CTRL_DA[8*(5-k) +: 8];
        else if (k < 12)  return f.sa[8*(11-k) +: 8];
        else if (k == 12) return 8'h88;
        else if (k == 13) return 8'h08;
        else if (k == 14) return {7'h0, f.pfc};
        else if (k == 15) return 8'h01;
        else if (k == 16) return f.pfc ? 8'h00 : f.slot[0][15:8];
        else if (k == 17) return f.pfc ? f.pev : f.slot[0][7:0];
        else if (k < 34 && f.pfc) begin
            p = (k - 18) / 2;
            w = f.slot[p];
            return ((k - 18) % 2 == 0) ? w[15:8] : w[7:0];
        end
        return 8'h00;
    endfunction
endpackage

// File: rtl/fc_req_latch.sv
module fc_req_latch #(
    parameter int NQ = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pfc_mode_i,
    input  logic [NQ-1:0] trig_set_i,
    input  logic [NQ-1:0] trig_rel_i,
    input  logic [NQ-1:0] zq_en_i,
    input  logic          take_i,
    output logic [NQ-1:0] pend_set_o,
    output logic [NQ-1:0] pend_rel_o
);
    logic [NQ-1:0] allow;
    logic [NQ-1:0] set_in;
    logic [NQ-1:0] rel_in;

    for (genvar q = 0; q < NQ; q++) begin : g_allow
        if (q == 0) begin : g_q0
            assign allow[q] = 1'b1;
        end else begin : g_qn
            assign allow[q] = pfc_mode_i;
        end
    end

    assign set_in = trig_set_i & allow;
    assign rel_in = trig_rel_i & zq_en_i & allow & ~set_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_set_o <= '0;
            pend_rel_o <= '0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (set_in[q]) begin
                    pend_set_o[q] <= 1'b1;
                    pend_rel_o[q] <= 1'b0;
                end else if (rel_in[q]) begin
                    pend_set_o[q] <= 1'b0;
                    pend_rel_o[q] <= 1'b1;
                end else if (take_i) begin
                    pend_set_o[q] <= 1'b0;
                    pend_rel_o[q] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/fc_frame_build.sv
module fc_frame_build
    import fc_pkg::*;
#(
    parameter int NQ = 8
) (
    input  logic             pfc_mode_i,
    input  logic [47:0]      src_addr_i,
    input  logic [NQ-1:0]    pend_set_i,
    input  logic [NQ-1:0]    pend_rel_i,
    input  logic [16*NQ-1:0] pause_time_i,
    input  logic [8*NQ-1:0]  prio_mask_i,
    output fc_frame_t        frame_o
);
    always_comb begin
        frame_o     = '0;
        frame_o.pfc = pfc_mode_i;
        frame_o.sa  = src_addr_i;
        if (pfc_mode_i) begin
            // descending so the lowest queue index writes last and wins
            for (int q = NQ - 1; q >= 0; q--) begin
                if (pend_set_i[q] || pend_rel_i[q]) begin
                    frame_o.pev = frame_o.pev | prio_mask_i[8*q +: 8];
                    for (int p = 0; p < NPRI; p++) begin
                        if (prio_mask_i[8*q + p])
                            frame_o.slot[p] = pend_set_i[q] ? pause_time_i[16*q +: 16] : 16'h0;
                    end
                end
            end
        end else begin
            frame_o.slot[0] = pend_set_i[0] ? pause_time_i[15:0] : 16'h0;
        end
    end
endmodule

// File: rtl/fc_serializer.sv
module fc_serializer
    import fc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  fc_frame_t frame_i,
    output logic      take_o,
    input  logic      ready_i,
    output logic [7:0] data_o,
    output logic      valid_o,
    output logic      last_o
);
    localparam logic [5:0] LAST_IDX = 6'(FRAME_LEN - 1);
    localparam logic [5:0] BODY_IDX = 6'(BODY_LEN);

    fc_state_e   state;
    logic [5:0]  idx;
    logic [31:0] crc;
    fc_frame_t   snap;
    logic [31:0] fcs;
    logic [7:0]  cur;

    assign take_o  = (state == ST_IDLE) && start_i;
    assign fcs     = ~crc;
    assign valid_o = (state == ST_SEND);
    assign last_o  = valid_o && (idx == LAST_IDX);
    assign data_o  = valid_o ? cur : 8'h00;

    always_comb begin
        if (idx < BODY_IDX) cur = body_byte(snap, idx);
        else begin
            case (idx[1:0])
                2'd0:    cur = fcs[7:0];
                2'd1:    cur = fcs[15:8];
                2'd2:    cur = fcs[23:16];
                default: cur = fcs[31:24];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            crc   <= '1;
            snap  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    snap  <= frame_i;
                    idx   <= '0;
                    crc   <= '1;
                    state <= ST_SEND;
                end
                ST_SEND: if (ready_i) begin
                    if (idx < BODY_IDX) crc <= crc32_byte(crc, cur);
                    if (idx == LAST_IDX) state <= ST_IDLE;
                    idx <= idx + 6'd1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fc_frame_gen.sv
module fc_frame_gen
    import fc_pkg::*;
#(
    parameter int NQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [47:0]      src_addr_i,
    input  logic             pfc_mode_i,
    input  logic [NQ-1:0]    trig_set_i,
    input  logic [NQ-1:0]    trig_rel_i,
    input  logic [NQ-1:0]    zq_en_i,
    input  logic [16*NQ-1:0] pause_time_i,
    input  logic [8*NQ-1:0]  prio_mask_i,
    input  logic             tx_ready_i,
    output logic [7:0]       tx_data_o,
    output logic             tx_valid_o,
    output logic             tx_last_o
);
    logic [NQ-1:0] pend_set;
    logic [NQ-1:0] pend_rel;
    logic          take;
    fc_frame_t     frame;

    fc_req_latch #(.NQ(NQ)) u_latch (
        .clk(clk), .rst(rst), .pfc_mode_i(pfc_mode_i),
        .trig_set_i(trig_set_i), .trig_rel_i(trig_rel_i), .zq_en_i(zq_en_i),
        .take_i(take), .pend_set_o(pend_set), .pend_rel_o(pend_rel)
    );

    fc_frame_build #(.NQ(NQ)) u_build (
        .pfc_mode_i(pfc_mode_i), .src_addr_i(src_addr_i),
        .pend_set_i(pend_set), .pend_rel_i(pend_rel),
        .pause_time_i(pause_time_i), .prio_mask_i(prio_mask_i),
        .frame_o(frame)
    );

    fc_serializer u_ser (
        .clk(clk), .rst(rst), .start_i(|(pend_set | pend_rel)),
        .frame_i(frame), .take_o(take), .ready_i(tx_ready_i),
        .data_o(tx_data_o), .valid_o(tx_valid_o), .last_o(tx_last_o)
    );
endmodule

// File: rtl/fc_frame_gen_checker.sv
module fc_frame_gen_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_valid_o,
    input logic       tx_ready_i,
    input logic       tx_last_o,
    input logic [7:0] tx_data_o
);
    logic [5:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (tx_valid_o && tx_ready_i) cnt <= tx_last_o ? 6'd0 : cnt + 6'd1;
    end

    assert_first_byte_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && cnt == 6'd0) |-> tx_data_o == 8'h01);

    assert_opcode_low_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && cnt == 6'd15) |-> tx_data_o == 8'h01);

    assert_last_position_R8: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |-> (tx_last_o == (cnt == 6'd63)));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

    assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && tx_ready_i && tx_last_o) |=> !tx_valid_o);

    assert_last_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        tx_last_o |-> tx_valid_o);
endmodule

bind fc_frame_gen fc_frame_gen_checker u_chk (
    .clk(clk), .rst(rst), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .tx_last_o(tx_last_o), .tx_data_o(tx_data_o)
);

// File: tb/fc_frame_gen_bench.sv
module fc_frame_gen_bench;
    localparam int NQ = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic [47:0]   sa;
    logic          pfc;
    logic [NQ-1:0] tset, trel, zq;
    logic [15:0]   pt [NQ];
    logic [7:0]    mk [NQ];
    logic [16*NQ-1:0] pt_flat;
    logic [8*NQ-1:0]  mk_flat;
    logic          rdy;
    logic [7:0]    tx_data;
    logic          tx_valid, tx_last;

    for (genvar g = 0; g < NQ; g++) begin : g_flat
        assign pt_flat[16*g +: 16] = pt[g];
        assign mk_flat[8*g +: 8]   = mk[g];
    end

    fc_frame_gen #(.NQ(NQ)) u_fc_frame_gen (
        .clk(clk), .rst(rst), .src_addr_i(sa), .pfc_mode_i(pfc),
        .trig_set_i(tset), .trig_rel_i(trel), .zq_en_i(zq),
        .pause_time_i(pt_flat), .prio_mask_i(mk_flat), .tx_ready_i(rdy),
        .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input bit m, input logic [7:0] s, input logic [7:0] r,
                             output logic [7:0] e [64], output bit any);
        logic [7:0] al, es, er, pev, claimed;
        logic [15:0] slot [8];
        logic [31:0] c;
        al = m ? 8'hFF : 8'h01;
        es = s & al;
        er = r & zq & al & ~es;
        any = |(es | er);
        for (int k = 0; k < 64; k++) e[k] = 8'h00;
        e[0] = 8'h01; e[1] = 8'h80; e[2] = 8'hC2; e[3] = 8'h00; e[4] = 8'h00; e[5] = 8'h01;
        for (int k = 0; k < 6; k++) e[6+k] = sa[47-8*k -: 8];
        e[12] = 8'h88; e[13] = 8'h08;
        e[14] = m ? 8'h01 : 8'h00; e[15] = 8'h01;
        if (m) begin
            pev = 0; claimed = 0;
            for (int p = 0; p < 8; p++) slot[p] = 16'h0;
            for (int q = 0; q < 8; q++) begin
                if (es[q] | er[q]) begin
                    pev |= mk[q];
                    for (int p = 0; p < 8; p++) begin
                        if (mk[q][p] && !claimed[p]) begin
                            claimed[p] = 1'b1;
                            slot[p] = es[q] ? pt[q] : 16'h0;
                        end
                    end
                end
            end
            e[17] = pev;
            for (int p = 0; p < 8; p++) begin
                e[18+2*p] = slot[p][15:8];
                e[19+2*p] = slot[p][7:0];
            end
        end else begin
            e[16] = es[0] ? pt[0][15:8] : 8'h00;
            e[17] = es[0] ? pt[0][7:0]  : 8'h00;
        end
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 60; k++) begin
            c = c ^ {24'h0, e[k]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) e[60+i] = c[8*i +: 8];
    endtask

    task automatic collect(output logic [7:0] got [64], output int n,
                           output bit lastbad, output bit holdbad);
        int waitc;
        bit held;
        logic [7:0] hd;
        n = 0; waitc = 0; held = 0; hd = 0; lastbad = 0; holdbad = 0;
        for (int k = 0; k < 64; k++) got[k] = 8'h00;
        while (n < 64 && waitc < 3000) begin
            @(negedge clk);
            if (held && (!tx_valid || tx_data != hd)) holdbad = 1;
            held = 0;
            rdy = (($urandom % 4) != 0);
            #1;
            if (tx_valid && rdy) begin
                got[n] = tx_data;
                if (tx_last != (n == 63)) lastbad = 1;
                n++;
            end else if (tx_valid) begin
                held = 1; hd = tx_data;
            end else if (tx_last) lastbad = 1;
            waitc++;
        end
        @(negedge clk);
        rdy = 1'b0;
    endtask

    task automatic compare(input logic [7:0] got [64], input logic [7:0] e [64],
                           input int lo, input int hi, input string req, input string what);
        int bad;
        bad = -1;
        for (int k = hi; k >= lo; k--) if (got[k] !== e[k]) bad = k;
        if (bad < 0) chk(1, req, what, 0, 0);
        else chk(0, req, $sformatf("%s byte %0d", what, bad), got[bad], e[bad]);
    endtask

    task automatic check_frame(input logic [7:0] e [64], input bit m, input string tag);
        logic [7:0] got [64];
        int n;
        bit lb, hb;
        collect(got, n, lb, hb);
        chk(n == 64, "R8", {tag, " byte count"}, n, 64);
        chk(!lb, "R8", {tag, " last flag position"}, lb, 0);
        chk(!hb, "R8", {tag, " stall hold"}, hb, 0);
        compare(got, e, 0, 13, "R1", {tag, " header"});
        compare(got, e, 14, 15, "R2", {tag, " opcode"});
        compare(got, e, 16, 59, m ? "R4" : "R3", {tag, " payload"});
        compare(got, e, 60, 63, "R7", {tag, " fcs"});
    endtask

    task automatic pulse(input logic [7:0] s, input logic [7:0] r);
        @(negedge clk); tset = s; trel = r;
        @(negedge clk); tset = '0; trel = '0;
    endtask

    task automatic no_frame(input string req, input string tag);
        bit seen;
        seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (tx_valid) seen = 1;
        end
        chk(!seen, req, {tag, " no frame"}, seen, 0);
    endtask

    task automatic run_case(input bit m, input logic [7:0] s, input logic [7:0] r,
                            input string req, input string tag);
        logic [7:0] e [64];
        bit any;
        pfc = m;
        build_exp(m, s, r, e, any);
        pulse(s, r);
        if (any) check_frame(e, m, tag);
        else no_frame(req, tag);
    endtask

    initial begin
        logic [7:0] ea [64];
        logic [7:0] eb [64];
        bit anya, anyb;
        void'($urandom(32'd2024));
        rst = 1; sa = 48'h0A1B_2C3D_4E5F; pfc = 0; tset = '0; trel = '0; zq = '0; rdy = 0;
        for (int q = 0; q < NQ; q++) begin
            pt[q] = 16'h1000 + 16'(q * 16'h0111);
            mk[q] = 8'(1 << q);
        end
        repeat (4) @(negedge clk);
        rst = 0;
        #1;
        // R10: idle after reset
        chk(tx_valid == 0, "R10", "valid after reset", tx_valid, 0);
        chk(tx_last == 0, "R10", "last after reset", tx_last, 0);
        no_frame("R10", "after reset");

        // R3: standard pause frame from queue 0
        run_case(0, 8'h01, 8'h00, "R3", "pause q0");
        // R3: other queues discarded in standard mode
        run_case(0, 8'h08, 8'h00, "R3", "pause q3 ignored");
        // R3/R6: standard release with zero quanta
        zq = 8'h01;
        run_case(0, 8'h00, 8'h01, "R6", "pause q0 release");

        // R4/R5: single priority queue, mask covers priorities 0 and 2
        mk[4] = 8'h05; pt[4] = 16'hBEEF;
        run_case(1, 8'h10, 8'h00, "R5", "pfc q4");
        // R5: merged triggers
        mk[1] = 8'h02; mk[2] = 8'h40; mk[6] = 8'h80;
        run_case(1, 8'h46, 8'h00, "R5", "pfc merged");
        // R5: overlapping masks, lower queue owns slot 3
        mk[2] = 8'h0C; mk[5] = 8'h0A; pt[2] = 16'h2222; pt[5] = 16'h5555;
        run_case(1, 8'h24, 8'h00, "R5", "pfc overlap");
        // R6: release with zero quanta
        zq = 8'h10;
        run_case(1, 8'h00, 8'h10, "R6", "pfc q4 release");
        // R6: release without zero quanta discarded
        run_case(1, 8'h00, 8'h20, "R6", "pfc q5 release no zq");
        // R6: set and release together, set wins
        zq = 8'hFF;
        run_case(1, 8'h10, 8'h10, "R6", "pfc set+rel");

        // R9: request during a frame, contents frozen at start
        pfc = 1;
        build_exp(1, 8'h04, 8'h00, ea, anya);
        pulse(8'h04, 8'h00);
        fork
            check_frame(ea, 1, "R9 first");
            begin
                repeat (12) @(negedge clk);
                pt[2] = 16'h7777; pt[3] = 16'h3333;
                build_exp(1, 8'h0C, 8'h00, eb, anyb);
                pulse(8'h0C, 8'h00);
            end
        join
        check_frame(eb, 1, "R9 second");

        // random mix
        for (int it = 0; it < 24; it++) begin
            bit m;
            logic [7:0] s, r;
            m = 1'($urandom % 2);
            for (int q = 0; q < NQ; q++) begin
                pt[q] = 16'($urandom);
                mk[q] = 8'($urandom);
            end
            zq = 8'($urandom);
            sa = {16'($urandom), 32'($urandom)};
            s = 8'($urandom) & 8'($urandom);
            r = 8'($urandom) & 8'($urandom);
            run_case(m, s, r, m ? "R5" : "R3", $sformatf("random %0d", it));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule